// File: doc/BRIEF.md
# Chained Audio Fragment DMA Engine

This block moves audio samples between system memory and a codec sample stream, one 32-bit word per memory transaction. It runs in one of two directions: in play direction it reads memory and hands words to the codec stream, and in record direction it takes words from the codec stream and writes them to memory. An internal FIFO sits between the memory side and the stream side.

Software describes a buffer as a sequence of fragments, each given as a base address and a byte count. The engine holds two fragment slots: the current fragment, which is being transferred, and a queued fragment. Software fills the queued slot while the current one runs. When the current fragment reaches terminal count, the engine takes the queued fragment and carries on with no idle cycle. A terminal-count flag and an error flag drive a level interrupt. A software reset bit stops transfers and discards what is left in the FIFO.

Software first loads a fragment and sets enable, which makes that fragment current. It then loads a second fragment at once. After that it refills the queued slot each time the terminal-count interrupt arrives.

Top module: `aud_chain_dma`

## Requirements
- R1: After reset, the control/status word at register offset 0 reads 0, `irq` is 0 and `mem_req` is 0.
- R2: Software writes the queued byte count at offset 1 and then the queued address at offset 2. The address write sets the slot-full flag, bit 13 of the control word. Offsets 1 and 2 read back the queued count and address.
- R3: While bit 13 is set, writes to offsets 1 and 2 are ignored and the stored values do not change.
- R4: The control word has enable at bit 0, direction at bit 1 (0 is play, 1 is record), interrupt enable at bit 2, chaining at bit 3 and soft reset at bit 4. If enable is set while no fragment is current and the slot is full, the queued fragment becomes current: bit 13 clears, the active flag (bit 16) sets, and offsets 3 and 4 show the current count and address.
- R5: In play direction the engine issues reads (`mem_we`=0) at the current address, rising by 4 per word. The words appear on the output sample stream in the order they were read.
- R6: In record direction the words taken from the input sample stream are written to memory (`mem_we`=1) in arrival order, at addresses rising by 4.
- R7: When the last word of a fragment completes, the terminal-count flag (bit 8) sets and interrupt pending (bit 12) reads 1. `irq` equals interrupt enable ANDed with interrupt pending.
- R8: If chaining is on and the slot is full at terminal count, the queued fragment is taken in the same cycle. The next memory request then follows with the same spacing as requests within a fragment. If chaining is on and the slot is empty, the active flag clears and enable stays 1. If chaining is off, enable clears.
- R9: Bits 8 and 9 clear when 1 is written to them, and writing 0 to them leaves them unchanged. Writing back a value read from offset 0 clears every flag that was set in it.
- R10: A memory response that comes with `mem_err` sets the error flag (bit 9) and interrupt pending, and it does not set terminal count.
- R11: Clearing enable stops new memory requests. A request already in flight stays asserted, with a stable address, until it is acknowledged, and the cycle-pending flag (bit 14) reads 1 during that time.
- R12: Setting soft reset clears the active flag and the slot-full flag and discards one FIFO word per cycle. The drain flag (bit 15) stays high while the FIFO holds data. A write that clears soft reset is ignored while the drain flag or the cycle-pending flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Level interrupt |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 for a memory write, 0 for a read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transaction complete |
| mem_err | input | 1 | Transaction completed with error |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| smp_out_valid | output | 1 | Play word available |
| smp_out_data | output | 32 | Play word |
| smp_out_ready | input | 1 | Codec accepts play word |
| smp_in_valid | input | 1 | Record word available |
| smp_in_data | input | 32 | Record word |
| smp_in_ready | output | 1 | Engine accepts record word |

## Verification
A broken fragment handover shows up directly on the memory port. A late or missing takeover of the queued slot adds an idle cycle before the first request of the second fragment, or sends that request to the wrong address. The bench compares the acknowledge spacing and the addresses at the boundary with those inside a fragment, so a fault is seen within two cycles of terminal count. Errors in flag state show up in the control word and on `irq` on the cycle after the event that caused them. These include a missed write-1-to-clear, a soft reset released early, and a queued slot that accepts an overwrite.

// File: rtl/aud_dma_pkg.sv
package aud_dma_pkg;

    localparam int BEAT_BYTES = 4;

    // control word bit positions
    localparam int B_EN    = 0;
    localparam int B_DIR   = 1;
    localparam int B_IE    = 2;
    localparam int B_CHAIN = 3;
    localparam int B_SRST  = 4;
    localparam int B_TC    = 8;
    localparam int B_ERR   = 9;
    localparam int B_INTP  = 12;
    localparam int B_NXTF  = 13;
    localparam int B_CYC   = 14;
    localparam int B_DRAIN = 15;
    localparam int B_ACT   = 16;

    typedef enum logic [2:0] {
        RA_CSR   = 3'd0,
        RA_NCNT  = 3'd1,
        RA_NADDR = 3'd2,
        RA_CCNT  = 3'd3,
        RA_CADDR = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic srst;
        logic chain;
        logic ie;
        logic dir;   // 0 play, 1 record
        logic en;
    } ctl_t;

    typedef struct packed {
        logic tc;
        logic err;
        logic nxtf;
        logic cyc;
        logic drain;
        logic act;
    } sts_t;

    function automatic logic [31:0] csr_word(input ctl_t c, input sts_t s);
        logic [31:0] w;
        w          = '0;
        w[B_EN]    = c.en;
        w[B_DIR]   = c.dir;
        w[B_IE]    = c.ie;
        w[B_CHAIN] = c.chain;
        w[B_SRST]  = c.srst;
        w[B_TC]    = s.tc;
        w[B_ERR]   = s.err;
        w[B_INTP]  = s.tc | s.err;
        w[B_NXTF]  = s.nxtf;
        w[B_CYC]   = s.cyc;
        w[B_DRAIN] = s.drain;
        w[B_ACT]   = s.act;
        return w;
    endfunction

endpackage

// File: rtl/aud_dma_fifo.sv
module aud_dma_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] store [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = store[rp];

    always_ff @(posedge clk) begin
        if (do_push) store[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (rst) !(push && full));  // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) !(pop && empty));  // R5

endmodule

// File: rtl/aud_dma_regs.sv
module aud_dma_regs
    import aud_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              beat_done,
    input  logic              beat_err,
    input  logic              drain,
    input  logic              cyc_pend,
    output ctl_t              ctl,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cur_act,
    output logic              irq
);
    localparam logic [CNT_W-1:0]  CNT_STEP  = CNT_W'(BEAT_BYTES);
    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(BEAT_BYTES);

    ctl_t              ctl_q;
    logic [CNT_W-1:0]  cur_cnt, nxt_cnt;
    logic [ADDR_W-1:0] cur_a, nxt_addr;
    logic              nxt_full, act, tc, err;
    logic              wr_csr, wr_ncnt, wr_naddr, last, idle_load, chain_load;
    sts_t              sts;

    assign wr_csr     = reg_wr && (reg_addr == RA_CSR);
    assign wr_ncnt    = reg_wr && (reg_addr == RA_NCNT);
    assign wr_naddr   = reg_wr && (reg_addr == RA_NADDR);
    assign last       = (cur_cnt <= CNT_STEP);
    assign idle_load  = !act && nxt_full && ctl_q.en && !ctl_q.srst;
    assign chain_load = beat_done && last && nxt_full && ctl_q.chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= '0;
            cur_cnt  <= '0;
            nxt_cnt  <= '0;
            cur_a    <= '0;
            nxt_addr <= '0;
            nxt_full <= 1'b0;
            act      <= 1'b0;
            tc       <= 1'b0;
            err      <= 1'b0;
        end else begin
            if (wr_csr) begin
                ctl_q.en    <= reg_wdata[B_EN];
                ctl_q.dir   <= reg_wdata[B_DIR];
                ctl_q.ie    <= reg_wdata[B_IE];
                ctl_q.chain <= reg_wdata[B_CHAIN];
                if (reg_wdata[B_SRST])
                    ctl_q.srst <= 1'b1;
                else if (!drain && !cyc_pend)
                    ctl_q.srst <= 1'b0;
            end
            if (wr_ncnt && !nxt_full)
                nxt_cnt <= reg_wdata[CNT_W-1:0];
            if (wr_naddr && !nxt_full) begin
                nxt_addr <= reg_wdata[ADDR_W-1:0];
                nxt_full <= 1'b1;
            end
            tc  <= (tc  && !(wr_csr && reg_wdata[B_TC]))  || (beat_done && last);
            err <= (err && !(wr_csr && reg_wdata[B_ERR])) || (beat_done && beat_err);

            if (ctl_q.srst) begin
                act      <= 1'b0;
                nxt_full <= 1'b0;
            end else if (idle_load || chain_load) begin
                cur_a    <= nxt_addr;
                cur_cnt  <= nxt_cnt;
                act      <= 1'b1;
                nxt_full <= 1'b0;
            end else if (beat_done) begin
                if (last) begin
                    act <= 1'b0;
                    if (!ctl_q.chain) ctl_q.en <= 1'b0;
                end else begin
                    cur_a   <= cur_a + ADDR_STEP;
                    cur_cnt <= cur_cnt - CNT_STEP;
                end
            end
        end
    end

    always_comb begin
        sts = '{tc: tc, err: err, nxtf: nxt_full, cyc: cyc_pend, drain: drain, act: act};
        case (reg_sel_e'(reg_addr))
            RA_CSR:   reg_rdata = csr_word(ctl_q, sts);
            RA_NCNT:  reg_rdata = 32'(nxt_cnt);
            RA_NADDR: reg_rdata = 32'(nxt_addr);
            RA_CCNT:  reg_rdata = 32'(cur_cnt);
            RA_CADDR: reg_rdata = 32'(cur_a);
            default:  reg_rdata = '0;
        endcase
    end

    assign ctl      = ctl_q;
    assign cur_addr = cur_a;
    assign cur_act  = act;
    assign irq      = ctl_q.ie && (tc || err);

    AST_SLOT_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (nxt_full && wr_naddr) |=> (nxt_addr == $past(nxt_addr)));  // R3
    AST_TC_ON_LAST: assert property (@(posedge clk) disable iff (rst)
        (beat_done && last) |=> tc);  // R7
    AST_CHAIN_NOGAP: assert property (@(posedge clk) disable iff (rst)
        (beat_done && last && nxt_full && ctl_q.chain && !ctl_q.srst) |=> (act && !nxt_full));  // R8
    AST_SRST_HELD: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.srst && (drain || cyc_pend)) |=> ctl_q.srst);  // R12

endmodule

// File: rtl/aud_dma_bus.sv
module aud_dma_bus #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              dir,
    input  logic              srst,
    input  logic              fifo_empty,
    input  logic              fifo_full,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [DATA_W-1:0] fifo_head,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    output logic              beat_done,
    output logic              beat_err,
    output logic              cyc_pend
);
    logic pend, we_q, issue;

    assign issue = !pend && run && (dir ? !fifo_empty : !fifo_full);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            we_q <= 1'b0;
        end else if (pend && mem_ack) begin
            pend <= 1'b0;
        end else if (issue) begin
            pend <= 1'b1;
            we_q <= dir;
        end
    end

    assign mem_req   = pend;
    assign mem_we    = we_q;
    assign mem_addr  = cur_addr;
    assign mem_wdata = fifo_head;
    assign cyc_pend  = pend;
    assign beat_done = pend && mem_ack && !srst;
    assign beat_err  = mem_err;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));  // R11
    AST_NO_NEW_REQ: assert property (@(posedge clk) disable iff (rst)
        (!mem_req && !run) |=> !mem_req);  // R11

endmodule

// File: rtl/aud_chain_dma.sv
module aud_chain_dma
    import aud_dma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 24,
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              smp_out_valid,
    output logic [DATA_W-1:0] smp_out_data,
    input  logic              smp_out_ready,
    input  logic              smp_in_valid,
    input  logic [DATA_W-1:0] smp_in_data,
    output logic              smp_in_ready
);
    ctl_t              ctl;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_act, beat_done, beat_err, cyc_pend, drain;
    logic              f_empty, f_full, f_push, f_pop, run;
    logic [DATA_W-1:0] f_din, f_head;

    assign run           = ctl.en && cur_act && !ctl.srst;
    assign drain         = ctl.srst && !f_empty;
    assign smp_out_valid = !ctl.dir && !ctl.srst && !f_empty;
    assign smp_out_data  = f_head;
    assign smp_in_ready  = ctl.dir && ctl.en && !ctl.srst && !f_full;

    assign f_din  = ctl.dir ? smp_in_data : mem_rdata;
    assign f_push = ctl.dir ? (smp_in_valid && smp_in_ready) : (beat_done && !mem_we);
    assign f_pop  = drain || (smp_out_valid && smp_out_ready) || (beat_done && mem_we);

    aud_dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .beat_done(beat_done), .beat_err(beat_err), .drain(drain), .cyc_pend(cyc_pend),
        .ctl(ctl), .cur_addr(cur_addr), .cur_act(cur_act), .irq(irq)
    );

    aud_dma_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk(clk), .rst(rst), .run(run), .dir(ctl.dir), .srst(ctl.srst),
        .fifo_empty(f_empty), .fifo_full(f_full), .cur_addr(cur_addr), .fifo_head(f_head),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_err(mem_err),
        .beat_done(beat_done), .beat_err(beat_err), .cyc_pend(cyc_pend)
    );

    aud_dma_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(f_push), .din(f_din), .pop(f_pop),
        .dout(f_head), .empty(f_empty), .full(f_full)
    );

endmodule

// File: tb/aud_chain_dma_test.sv
module aud_chain_dma_test;

    localparam logic [31:0] KEY = 32'hA5A5_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        smp_out_valid;
    logic [31:0] smp_out_data;
    logic        smp_out_ready = 1'b0;
    logic        smp_in_valid = 1'b0;
    logic [31:0] smp_in_data = '0;
    logic        smp_in_ready;

    aud_chain_dma uut (.*);

    always #5 clk = ~clk;

    int errs = 0, checks = 0, cyc = 0, log_n = 0;
    logic stall = 1'b0, err_arm = 1'b0, done = 1'b0;
    logic [31:0] log_addr [16];
    logic [31:0] log_data [16];
    logic        log_we   [16];
    int          log_cyc  [16];

    initial forever @(posedge clk) cyc++;

    // memory responder: one-cycle acknowledge, optional stall and error
    initial forever @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
        end else if (mem_req && !stall) begin
            mem_ack   = 1'b1;
            mem_err   = err_arm;
            err_arm   = 1'b0;
            mem_rdata = mem_addr ^ KEY;
            if (log_n < 16) begin
                log_addr[log_n] = mem_addr;
                log_data[log_n] = mem_wdata;
                log_we[log_n]   = mem_we;
                log_cyc[log_n]  = cyc;
            end
            log_n++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_csr_bit(input int b, input logic v);
        logic [31:0] r;
        for (int i = 0; i < 200; i++) begin
            reg_read(3'd0, r);
            if (r[b] == v) break;
            @(negedge clk);
        end
    endtask

    task automatic push_word(input logic [31:0] d);
        smp_in_valid = 1'b1; smp_in_data = d;
        for (int i = 0; i < 20; i++) begin
            if (smp_in_ready) begin
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        smp_in_valid = 1'b0;
    endtask

    typedef struct packed {
        logic        wr;
        logic [2:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    // register-port vectors: R1 reset reads, R2 slot arming, R3 slot lock
    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 3'd0, 32'h0000_0000, 4'd1},
        '{1'b0, 3'd1, 32'h0000_0000, 4'd1},
        '{1'b1, 3'd1, 32'h0000_0010, 4'd2},
        '{1'b0, 3'd1, 32'h0000_0010, 4'd2},
        '{1'b0, 3'd0, 32'h0000_0000, 4'd2},
        '{1'b1, 3'd2, 32'h0000_1000, 4'd2},
        '{1'b0, 3'd0, 32'h0000_2000, 4'd2},
        '{1'b0, 3'd2, 32'h0000_1000, 4'd2},
        '{1'b1, 3'd1, 32'h0000_0040, 4'd3},
        '{1'b1, 3'd2, 32'h0000_2000, 4'd3},
        '{1'b0, 3'd1, 32'h0000_0010, 4'd3},
        '{1'b0, 3'd2, 32'h0000_1000, 4'd3},
        '{1'b0, 3'd0, 32'h0000_2000, 4'd3}
    };

    initial begin
        logic [31:0] r, v;
        int got;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 mem_req", {31'b0, mem_req}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) reg_write(VEC[i].addr, VEC[i].data);
            else begin
                reg_read(VEC[i].addr, r);
                chk($sformatf("R%0d vec%0d", VEC[i].req, i), r, VEC[i].data);
            end
        end

        // R4: enable promotes queued fragment
        reg_write(3'd0, 32'h0000_000C);
        reg_write(3'd0, 32'h0000_000D);
        @(negedge clk);
        reg_read(3'd0, r);
        chk("R4 active", {31'b0, r[16]}, 32'h1);
        chk("R4 slot freed", {31'b0, r[13]}, 32'h0);
        reg_read(3'd4, r);
        chk("R4 cur addr", r, 32'h0000_1000);
        reg_read(3'd3, r);
        chk("R4 cur cnt", r, 32'h0000_0010);
        reg_write(3'd1, 32'h0000_0008);
        reg_write(3'd2, 32'h0000_3000);
        wait_csr_bit(16, 1'b0);
        repeat (2) @(negedge clk);

        // R5 and R8: play addresses and chain spacing
        chk("R5 beats", log_n, 6);
        for (int i = 0; i < 6; i++) begin
            logic [31:0] ea;
            ea = (i < 4) ? 32'h1000 + 32'(4 * i) : 32'h3000 + 32'(4 * (i - 4));
            chk($sformatf("R5 addr%0d", i), log_addr[i], ea);
            chk($sformatf("R5 we%0d", i), {31'b0, log_we[i]}, 32'h0);
        end
        for (int i = 1; i < 6; i++)
            chk($sformatf("R8 spacing%0d", i), log_cyc[i] - log_cyc[i-1], 2);
        reg_read(3'd0, r);
        chk("R7 tc", {31'b0, r[8]}, 32'h1);
        chk("R7 intp", {31'b0, r[12]}, 32'h1);
        chk("R7 irq", {31'b0, irq}, 32'h1);
        chk("R8 en held", {31'b0, r[0]}, 32'h1);
        chk("R8 slot empty", {31'b0, r[13]}, 32'h0);

        // R5 stream order
        smp_out_ready = 1'b1;
        got = 0;
        for (int i = 0; i < 40 && got < 6; i++) begin
            if (smp_out_valid) begin
                chk($sformatf("R5 stream%0d", got), smp_out_data, log_addr[got] ^ KEY);
                got++;
            end
            @(negedge clk);
        end
        smp_out_ready = 1'b0;
        chk("R5 stream count", got, 6);

        // R9: write-0 keeps, write-back clears
        reg_write(3'd0, 32'h0000_000D);
        reg_read(3'd0, r);
        chk("R9 write0 keeps tc", {31'b0, r[8]}, 32'h1);
        reg_read(3'd0, v);
        reg_write(3'd0, v);
        reg_read(3'd0, r);
        chk("R9 writeback clears tc", {31'b0, r[8]}, 32'h0);
        chk("R9 irq low", {31'b0, irq}, 32'h0);
        reg_write(3'd0, 32'h0);

        // R6 record, R8 no-chain stop
        reg_write(3'd0, 32'h0000_0002);
        reg_write(3'd1, 32'h0000_0008);
        reg_write(3'd2, 32'h0000_5000);
        log_n = 0;
        reg_write(3'd0, 32'h0000_0007);
        for (int i = 0; i < 3; i++) push_word(32'hC0DE_0000 + 32'(i));
        wait_csr_bit(8, 1'b1);
        repeat (3) @(negedge clk);
        chk("R6 beats", log_n, 2);
        for (int i = 0; i < 2; i++) begin
            chk($sformatf("R6 addr%0d", i), log_addr[i], 32'h5000 + 32'(4 * i));
            chk($sformatf("R6 data%0d", i), log_data[i], 32'hC0DE_0000 + 32'(i));
            chk($sformatf("R6 we%0d", i), {31'b0, log_we[i]}, 32'h1);
        end
        reg_read(3'd0, r);
        chk("R8 no chain clears en", {31'b0, r[0]}, 32'h0);

        // R12: soft reset, drain and held reset bit
        reg_write(3'd1, 32'h0000_0008);
        reg_write(3'd2, 32'h0000_9000);
        reg_read(3'd0, r);
        chk("R12 slot full before", {31'b0, r[13]}, 32'h1);
        reg_write(3'd0, 32'h0000_0012);
        reg_read(3'd0, r);
        chk("R12 drain high", {31'b0, r[15]}, 32'h1);
        reg_write(3'd0, 32'h0000_0002);
        reg_read(3'd0, r);
        chk("R12 srst held", {31'b0, r[4]}, 32'h1);
        chk("R12 drain done", {31'b0, r[15]}, 32'h0);
        chk("R12 slot cleared", {31'b0, r[13]}, 32'h0);
        reg_write(3'd0, 32'h0000_0302);
        reg_read(3'd0, r);
        chk("R12 srst released", r, 32'h0000_0002);

        // R11: enable clear with stalled cycle
        reg_write(3'd0, 32'h0000_0000);
        stall = 1'b1;
        log_n = 0;
        reg_write(3'd1, 32'h0000_0010);
        reg_write(3'd2, 32'h0000_7000);
        reg_write(3'd0, 32'h0000_0009);
        repeat (4) @(negedge clk);
        chk("R11 req up", {31'b0, mem_req}, 32'h1);
        chk("R11 addr", mem_addr, 32'h0000_7000);
        reg_write(3'd0, 32'h0000_0008);
        @(negedge clk);
        reg_read(3'd0, r);
        chk("R11 req held", {31'b0, mem_req}, 32'h1);
        chk("R11 cyc pend", {31'b0, r[14]}, 32'h1);
        stall = 1'b0;
        repeat (6) @(negedge clk);
        reg_read(3'd0, r);
        chk("R11 no new req", {31'b0, mem_req}, 32'h0);
        chk("R11 cyc clear", {31'b0, r[14]}, 32'h0);
        chk("R11 one beat", log_n, 1);

        // R10: error response
        err_arm = 1'b1;
        reg_write(3'd0, 32'h0000_0009);
        for (int i = 0; i < 20 && log_n < 2; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        reg_read(3'd0, r);
        chk("R10 err", {31'b0, r[9]}, 32'h1);
        chk("R10 no tc", {31'b0, r[8]}, 32'h0);
        chk("R10 intp", {31'b0, r[12]}, 32'h1);
        chk("R7 irq gated", {31'b0, irq}, 32'h0);
        chk("R10 addr", log_addr[1], 32'h0000_7004);
        reg_write(3'd0, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        wait (cyc >= 20000);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=finish", cyc);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule